// File: doc/BRIEF.md
# Byte-Stuffed Packet Deframer

This block turns a byte stream that carries packets into payload bytes marked with packet boundaries. Three adjacent code values are reserved for control: an opener, a closer and an escape prefix. Each payload byte that equals a reserved value is sent as a two-byte pair: the escape prefix, then a small substitute code. The deframer removes these pairs, strips the delimiters, and presents each payload byte with a valid strobe. It marks the first byte of a packet with a start flag and the last byte with an end flag.

The opener can never occur inside a packet. For that reason the block treats an opener as the start of a fresh packet in every state, and it regains framing after any fault without outside help. Protocol violations raise a one-cycle error pulse and discard the rest of the damaged packet. Each payload byte is delayed by one accepted byte. This delay lets the end flag ride on the last payload byte, because the closer has been seen by the time that byte leaves.

Top module: `bstuff_deframer`

## Requirements
- R1: After reset, every output is low and the block waits outside a packet.
- R2: Outside a packet, any accepted byte other than the opener 0xFE produces no output and no error.
- R3: Inside a packet, each accepted byte from 0x00 to 0xFC is delivered unchanged and in arrival order on `out_byte` with `out_valid` high.
- R4: Inside a packet, the pairs 0xFD 0x0D, 0xFD 0x0E and 0xFD 0x0F each deliver one payload byte, 0xFD, 0xFE and 0xFF respectively. The prefix byte delivers nothing.
- R5: `out_sop` is high together with `out_valid` on the first payload byte after an opener, and on no other byte.
- R6: A payload byte appears on the outputs in the cycle after the next payload byte or closer 0xFF is accepted. When a closer ends the packet, the last byte carries `out_eop` high, and `out_eop` is never high without `out_valid`.
- R7: An opener followed directly by a closer produces no output and no error.
- R8: An opener accepted inside a packet, including right after an escape prefix, raises `out_err` for one cycle one cycle later. The pending payload byte is discarded and a new packet begins.
- R9: After an escape prefix, a byte that is none of 0x0D, 0x0E, 0x0F or the opener raises `out_err`, discards the pending byte and leaves the packet. Later bytes are ignored until the next opener.
- R10: A closer that directly follows an escape prefix raises `out_err`, discards the pending byte and leaves the packet, with no `out_eop`.
- R11: Cycles with `in_valid` low change nothing, and `out_err` is never high in the same cycle as `out_valid`.
- R12: The reserved codes are parameters: the escape prefix is `RSV_BASE`, the opener is `RSV_BASE+1` and the closer is `RSV_BASE+2`. The substitute codes are `SFX_BASE+0..2` in the same order. Elaboration rejects code sets that overlap or overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | DW | Received line byte |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | DW | Payload byte |
| out_sop | output | 1 | First payload byte of a packet |
| out_eop | output | 1 | Last payload byte of a packet |
| out_err | output | 1 | One-cycle protocol violation pulse |

## Verification
The hardest state to reach is an escape prefix that is still pending while a byte is held back. If an opener or closer arrives in that state, the block must drop the held byte, signal one error and end up in the right state. Directed sequences place opener, closer, bad suffixes and valid suffixes directly after a prefix that follows real payload. A long random stream weighted heavily toward the reserved and substitute codes then reaches these states again with gaps in `in_valid`. A behavioural model in the bench checks every cycle of that stream.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BODY = 2'd1,
      ST_ESC  = 2'd2
   } bsd_state_t;

   localparam int NUM_RSV = 3;   // prefix, opener, closer
endpackage

// File: rtl/bsd_classify.sv
module bsd_classify #(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] RSV_BASE = 8'hFD,
   parameter logic [DW-1:0] SFX_BASE = 8'h0D
) (
   input  logic [DW-1:0] byte_i,
   output logic          is_esc,
   output logic          is_sof,
   output logic          is_eof,
   output logic          sfx_ok,
   output logic [DW-1:0] sfx_val
);
   import bsd_pkg::*;

   logic [NUM_RSV-1:0] hit_rsv;
   logic [NUM_RSV-1:0] hit_sfx;

   if (int'(RSV_BASE) + NUM_RSV > (1 << DW)) begin : g_bad_rsv
      $error("reserved codes overflow the byte width");
   end
   if (int'(SFX_BASE) + NUM_RSV > int'(RSV_BASE)) begin : g_bad_sfx
      $error("substitute codes must lie below the reserved codes");
   end

   for (genvar i = 0; i < NUM_RSV; i++) begin : g_code
      localparam logic [DW-1:0] RC = DW'(int'(RSV_BASE) + i);
      localparam logic [DW-1:0] SC = DW'(int'(SFX_BASE) + i);
      assign hit_rsv[i] = (byte_i == RC);
      assign hit_sfx[i] = (byte_i == SC);
   end

   assign is_esc = hit_rsv[0];
   assign is_sof = hit_rsv[1];
   assign is_eof = hit_rsv[2];
   assign sfx_ok = |hit_sfx;

   always_comb begin
      sfx_val = '0;
      for (int k = 0; k < NUM_RSV; k++) begin
         if (hit_sfx[k]) sfx_val = DW'(int'(RSV_BASE) + k);
      end
   end
endmodule

// File: rtl/bsd_fsm.sv
module bsd_fsm #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_byte,
   input  logic          is_esc,
   input  logic          is_sof,
   input  logic          is_eof,
   input  logic          sfx_ok,
   input  logic [DW-1:0] sfx_val,
   output logic          pay_v,
   output logic [DW-1:0] pay_d,
   output logic          pay_first,
   output logic          fin,
   output logic          drop,
   output logic          err
);
   import bsd_pkg::*;

   bsd_state_t st, st_nxt;
   logic       first_q;

   always_comb begin
      st_nxt = st;
      pay_v  = 1'b0;
      pay_d  = in_byte;
      fin    = 1'b0;
      drop   = 1'b0;
      err    = 1'b0;
      if (in_valid) begin
         unique case (st)
            ST_IDLE: if (is_sof) st_nxt = ST_BODY;
            ST_BODY: begin
               if (is_sof) begin
                  err = 1'b1; drop = 1'b1;
               end else if (is_eof) begin
                  fin = 1'b1; st_nxt = ST_IDLE;
               end else if (is_esc) begin
                  st_nxt = ST_ESC;
               end else begin
                  pay_v = 1'b1;
               end
            end
            ST_ESC: begin
               if (is_sof) begin
                  err = 1'b1; drop = 1'b1; st_nxt = ST_BODY;
               end else if (sfx_ok) begin
                  pay_v = 1'b1; pay_d = sfx_val; st_nxt = ST_BODY;
               end else begin
                  err = 1'b1; drop = 1'b1; st_nxt = ST_IDLE;
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
      end
   end

   assign pay_first = first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         first_q <= 1'b0;
      end else begin
         st <= st_nxt;
         if (in_valid && is_sof) first_q <= 1'b1;
         else if (pay_v)         first_q <= 1'b0;
      end
   end

   p_sof_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_sof) |=> (st == ST_BODY && first_q));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && in_valid && !is_sof) |-> (!pay_v && !err && !fin));

   p_eof_exits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_eof && st != ST_IDLE) |=> (st == ST_IDLE));
endmodule

// File: rtl/bsd_hold.sv
module bsd_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pay_v,
   input  logic [DW-1:0] pay_d,
   input  logic          pay_first,
   input  logic          fin,
   input  logic          drop,
   input  logic          err,
   output logic          out_valid,
   output logic [DW-1:0] out_byte,
   output logic          out_sop,
   output logic          out_eop,
   output logic          out_err
);
   logic          hold_v;
   logic [DW-1:0] hold_d;
   logic          hold_sop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_d    <= '0;
         hold_sop  <= 1'b0;
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_err   <= err;
         if (drop) begin
            hold_v <= 1'b0;
         end else if (fin) begin
            if (hold_v) begin
               out_valid <= 1'b1;
               out_byte  <= hold_d;
               out_sop   <= hold_sop;
               out_eop   <= 1'b1;
            end
            hold_v <= 1'b0;
         end else if (pay_v) begin
            if (hold_v) begin
               out_valid <= 1'b1;
               out_byte  <= hold_d;
               out_sop   <= hold_sop;
            end
            hold_v   <= 1'b1;
            hold_d   <= pay_d;
            hold_sop <= pay_first;
         end
      end
   end

   p_eop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> out_valid);

   p_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_err && out_valid));

   p_drop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !hold_v);
endmodule

// File: rtl/bstuff_deframer.sv
module bstuff_deframer #(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] RSV_BASE = 8'hFD,
   parameter logic [DW-1:0] SFX_BASE = 8'h0D
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_byte,
   output logic          out_valid,
   output logic [DW-1:0] out_byte,
   output logic          out_sop,
   output logic          out_eop,
   output logic          out_err
);
   logic          is_esc, is_sof, is_eof, sfx_ok;
   logic [DW-1:0] sfx_val;
   logic          pay_v, pay_first, fin, drop, err;
   logic [DW-1:0] pay_d;

   bsd_classify #(.DW(DW), .RSV_BASE(RSV_BASE), .SFX_BASE(SFX_BASE)) u_cls (
      .byte_i (in_byte),
      .is_esc (is_esc),
      .is_sof (is_sof),
      .is_eof (is_eof),
      .sfx_ok (sfx_ok),
      .sfx_val(sfx_val)
   );

   bsd_fsm #(.DW(DW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .is_esc   (is_esc),
      .is_sof   (is_sof),
      .is_eof   (is_eof),
      .sfx_ok   (sfx_ok),
      .sfx_val  (sfx_val),
      .pay_v    (pay_v),
      .pay_d    (pay_d),
      .pay_first(pay_first),
      .fin      (fin),
      .drop     (drop),
      .err      (err)
   );

   bsd_hold #(.DW(DW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .pay_v    (pay_v),
      .pay_d    (pay_d),
      .pay_first(pay_first),
      .fin      (fin),
      .drop     (drop),
      .err      (err),
      .out_valid(out_valid),
      .out_byte (out_byte),
      .out_sop  (out_sop),
      .out_eop  (out_eop),
      .out_err  (out_err)
   );
endmodule

// File: tb/sim_bstuff_deframer.sv
`timescale 1ns/1ps
module sim_bstuff_deframer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_sop, out_eop, out_err;
   logic [7:0] out_byte;

   always #2 clk = ~clk;

   bstuff_deframer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
      .out_eop(out_eop), .out_err(out_err)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [8:0] sq[$];
   string      tq[$];

   // reference model state: 0 outside, 1 in packet, 2 after prefix
   int         m_st = 0;
   bit         m_first = 0;
   bit         m_hv = 0;
   logic [7:0] m_hd = 0;
   bit         m_hsop = 0;
   bit         e_v, e_sop, e_eop, e_err;
   logic [7:0] e_d;
   logic [7:0] e_d_keep = 8'h00;

   task automatic push(input bit v, input logic [7:0] b, input string tag);
      sq.push_back({v, b});
      tq.push_back(tag);
   endtask

   task automatic pushs(input logic [7:0] bs[], input string tag);
      foreach (bs[i]) push(1'b1, bs[i], tag);
   endtask

   task automatic m_emit(input bit eop);
      e_v = 1; e_d = m_hd; e_sop = m_hsop; e_eop = eop;
   endtask

   task automatic m_pay(input logic [7:0] x);
      if (m_hv) m_emit(1'b0);
      m_hd = x; m_hsop = m_first; m_first = 0; m_hv = 1;
   endtask

   task automatic model(input bit v, input logic [7:0] b);
      e_v = 0; e_sop = 0; e_eop = 0; e_err = 0; e_d = e_d_keep;
      if (v) begin
         case (m_st)
            0: if (b == 8'hFE) begin m_st = 1; m_first = 1; end
            1: begin
               if (b == 8'hFE) begin e_err = 1; m_hv = 0; m_first = 1; end
               else if (b == 8'hFF) begin if (m_hv) m_emit(1'b1); m_hv = 0; m_st = 0; end
               else if (b == 8'hFD) m_st = 2;
               else m_pay(b);
            end
            default: begin
               if (b == 8'hFE) begin e_err = 1; m_hv = 0; m_first = 1; m_st = 1; end
               else if (b == 8'hFF) begin e_err = 1; m_hv = 0; m_st = 0; end
               else if (b >= 8'h0D && b <= 8'h0F) begin m_pay(b + 8'hF0); m_st = 1; end
               else begin e_err = 1; m_hv = 0; m_st = 0; end
            end
         endcase
      end
      if (e_v) e_d_keep = e_d;
   endtask

   task automatic check(input string tag);
      checks++;
      if (out_valid !== e_v || out_sop !== e_sop || out_eop !== e_eop ||
          out_err !== e_err || (e_v && out_byte !== e_d)) begin
         errors++;
         $display("FAIL %s: got v=%b d=%h sop=%b eop=%b err=%b exp v=%b d=%h sop=%b eop=%b err=%b",
                  tag, out_valid, out_byte, out_sop, out_eop, out_err,
                  e_v, e_d, e_sop, e_eop, e_err);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      string cur;
      // directed stimulus
      pushs('{8'h00, 8'hFD, 8'hFF, 8'h41, 8'h0E}, "R2 idle ignore");
      pushs('{8'hFE, 8'h01, 8'h02, 8'hFC, 8'hFF}, "R3 R5 R6 plain packet");
      pushs('{8'hFE, 8'hFD, 8'h0D, 8'hFD, 8'h0E, 8'hFD, 8'h0F, 8'h55, 8'hFF}, "R4 escapes");
      pushs('{8'hFE, 8'hFF, 8'h00}, "R7 empty packet");
      pushs('{8'hFE, 8'h10, 8'h20, 8'hFE, 8'h30, 8'hFF}, "R8 abort restart");
      pushs('{8'hFE, 8'h11, 8'hFD, 8'hFE, 8'h44, 8'hFF}, "R8 opener after prefix");
      pushs('{8'hFE, 8'h11, 8'hFD, 8'h22, 8'h33, 8'hFF}, "R9 bad suffix");
      pushs('{8'hFE, 8'h12, 8'hFD, 8'hFF, 8'h13}, "R10 closer after prefix");
      push(1, 8'hFE, "R11 gaps"); push(0, 8'hFE, "R11 gaps");
      push(1, 8'h21, "R11 gaps"); push(0, 8'hFF, "R11 gaps");
      push(1, 8'hFD, "R11 gaps"); push(0, 8'hFE, "R11 gaps");
      push(1, 8'h0E, "R11 gaps"); push(0, 8'h00, "R11 gaps");
      push(1, 8'hFF, "R11 gaps");
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] b;
         int r;
         r = int'($urandom % 10);
         if (r < 2)      b = 8'hFD + 8'($urandom % 3);
         else if (r < 4) b = 8'h0D + 8'($urandom % 3);
         else            b = 8'($urandom);
         push(($urandom % 5) != 0, b, "R3 R12 random stream");
      end
      for (int n = 0; n < 4; n++) push(0, 8'h00, "R11 drain");

      e_v = 0; e_sop = 0; e_eop = 0; e_err = 0; e_d = 0;
      repeat (3) @(negedge clk);
      check("R1 reset state");
      rst_n = 1'b1;
      cur = "R1 after reset";
      while (sq.size() > 0) begin
         logic [8:0] it;
         @(negedge clk);
         check(cur);
         it = sq.pop_front();
         cur = tq.pop_front();
         in_valid = it[8];
         in_byte  = it[7:0];
         model(it[8], it[7:0]);
      end
      @(negedge clk);
      check(cur);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule